// File: doc/BRIEF.md
# Banked Memory View Routing Adapter

This block sits between a group of parallel processing lanes and a cyclically banked memory of `NUM_BANKS` banks, each `BANK_DEPTH` words deep, where word `p` lives in bank `p mod NUM_BANKS` at in-bank address `p / NUM_BANKS`. Each lane presents a local view index. The adapter turns that index into a physical bank select and an in-bank address, routes each lane onto the bank it targets, and flags bank collisions. It holds no storage and does no arbitration beyond the collision flag.

Three view modes are held in a configuration register. The aligned suffix view adds a base of `NUM_BANKS * e` words, so a lane's bank is simply its index's low bits and only the address moves. The shift view adds an arbitrary base, so bank and address are both recomputed and any lane can land on any bank. The shrink view divides the logical bank count by `SHRINK`. Only the first `NUM_BANKS/SHRINK` lanes take part, and each one picks among its own `SHRINK` physical banks with a small multiplexer. An access whose physical index runs past the end of the memory is flagged and not routed. It never wraps.

Top module: `view_route_adapter`

## Requirements
- R1: After reset the mode is suffix (encoding 0) and the base is 0, so a valid lane with index i is routed to bank i mod NUM_BANKS at address i / NUM_BANKS.
- R2: Mode and base are loaded from cfg_mode_i and cfg_base_i on a rising clock edge while cfg_we_i is high. They affect routing from that edge on, and are held unchanged while cfg_we_i is low.
- R3: In suffix mode (encoding 0), the physical index is NUM_BANKS*base + i. The bank equals the low log2(NUM_BANKS) bits of i, and the address is the physical index / NUM_BANKS.
- R4: In shift mode (encoding 1; encoding 3 behaves the same), the physical index is base + i. The bank is the physical index mod NUM_BANKS and the address is the physical index / NUM_BANKS.
- R5: In shift mode, with every lane valid and lane l presenting index l, conflict_o stays low for every base.
- R6: In shrink mode (encoding 2), the base is ignored and the physical index is i. Only lanes l < NUM_BANKS/SHRINK are enabled. Lane l drives bank k*G + (l mod G), where G = NUM_BANKS/SHRINK and k = (i mod NUM_BANKS) / G.
- R7: When the physical index is at least NUM_BANKS*BANK_DEPTH, lane_oor_o is high and the lane is not enabled or routed to any bank.
- R8: bank_en_o[b] is high when at least one enabled lane targets bank b. bank_addr_o[b] and bank_lane_o[b] then come from the lowest-numbered such lane.
- R9: conflict_o is high when two enabled lanes target the same bank with different addresses. Lanes sharing a bank and an address do not conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Load mode and base |
| cfg_mode_i | input | 2 | View mode: 0 suffix, 1 shift, 2 shrink, 3 shift |
| cfg_base_i | input | IW | Base: multiplier in suffix mode, word offset in shift mode |
| lane_vld_i | input | LANES | Per-lane access request |
| lane_idx_i | input | LANES*IW | Per-lane local view index |
| lane_bank_o | output | LANES*NBW | Per-lane physical bank select |
| lane_addr_o | output | LANES*AW | Per-lane in-bank address |
| lane_en_o | output | LANES | Lane routed to a bank |
| lane_oor_o | output | LANES | Lane physical index past end of memory |
| bank_en_o | output | NUM_BANKS | Bank accessed this cycle |
| bank_addr_o | output | NUM_BANKS*AW | Address seen by each bank |
| bank_lane_o | output | NUM_BANKS*LW | Lane that owns each bank |
| conflict_o | output | 1 | Two lanes hit one bank at different addresses |

## Verification
On every cycle, the assertions check the following: the configuration holds unless written, suffix-mode banks follow the index's low bits, upper lanes stay idle in shrink mode, no enabled bank sees an address past its depth, consecutive shift-mode indices never conflict, and a conflict always involves at least two enabled lanes. Only the bench's scenarios can show the exact address arithmetic of each mode. Its sweep over every base value compares each lane's and each bank's outputs with an index model. It also checks the out-of-range boundary, lowest-lane ownership of a shared bank, and the difference between a shared read and a true conflict.

// File: rtl/view_route_pkg.sv
package view_route_pkg;
  typedef enum logic [1:0] {
    VM_SUFFIX = 2'd0,
    VM_SHIFT  = 2'd1,
    VM_SHRINK = 2'd2,
    VM_RSVD   = 2'd3
  } view_mode_e;
endpackage

// File: rtl/view_cfg_reg.sv
module view_cfg_reg
  import view_route_pkg::*;
#(
  parameter int IW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    mode_i,
  input  logic [IW-1:0] base_i,
  output view_mode_e    mode_o,
  output logic [IW-1:0] base_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= VM_SUFFIX;
      base_o <= '0;
    end else if (we_i) begin
      mode_o <= view_mode_e'(mode_i);
      base_o <= base_i;
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(mode_o) && $stable(base_o))); // R2
  AST_CFG_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (base_o == $past(base_i))); // R2
endmodule

// File: rtl/view_lane_map.sv
module view_lane_map
  import view_route_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int BANK_DEPTH = 3,
  parameter int SHRINK     = 2,
  parameter int LANE       = 0,
  parameter int IW         = 4,
  parameter int AW         = 2,
  parameter int NBW        = 2
) (
  input  view_mode_e     mode_i,
  input  logic [IW-1:0]  base_i,
  input  logic           vld_i,
  input  logic [IW-1:0]  idx_i,
  output logic [NBW-1:0] bank_o,
  output logic [AW-1:0]  addr_o,
  output logic           en_o,
  output logic           oor_o
);
  localparam int SW    = IW + NBW + 1;
  localparam int WORDS = NUM_BANKS * BANK_DEPTH;
  localparam int G     = NUM_BANKS / SHRINK;
  localparam int GW    = $clog2(G);
  localparam logic [NBW-1:0] SLOT = NBW'(LANE % G);
  localparam bit IN_SHRINK = (LANE < G);

  logic [SW-1:0]  phys;
  logic [NBW-1:0] own_bank;

  assign own_bank = idx_i[NBW-1:0];

  always_comb begin
    unique case (mode_i)
      VM_SUFFIX: begin
        // aligned base: bank is hard-wired to the index low bits
        phys   = (SW'(base_i) << NBW) + SW'(idx_i);
        bank_o = own_bank;
      end
      VM_SHRINK: begin
        // lane picks among its SHRINK banks: slot fixed, group from index
        phys   = SW'(idx_i);
        bank_o = ((own_bank >> GW) << GW) | SLOT;
      end
      default: begin
        phys   = SW'(base_i) + SW'(idx_i);
        bank_o = phys[NBW-1:0];
      end
    endcase
  end

  assign addr_o = AW'(phys >> NBW);
  assign oor_o  = (phys >= SW'(WORDS));
  assign en_o   = vld_i && !oor_o && ((mode_i != VM_SHRINK) || IN_SHRINK);
endmodule

// File: rtl/view_bank_xbar.sv
module view_bank_xbar #(
  parameter int NUM_BANKS = 4,
  parameter int LANES     = 4,
  parameter int AW        = 2,
  parameter int NBW       = 2,
  parameter int LW        = 2
) (
  input  logic [LANES-1:0]              lane_en_i,
  input  logic [LANES-1:0][NBW-1:0]     lane_bank_i,
  input  logic [LANES-1:0][AW-1:0]      lane_addr_i,
  output logic [NUM_BANKS-1:0]          bank_en_o,
  output logic [NUM_BANKS-1:0][AW-1:0]  bank_addr_o,
  output logic [NUM_BANKS-1:0][LW-1:0]  bank_lane_o,
  output logic                          conflict_o
);
  always_comb begin
    bank_en_o   = '0;
    bank_addr_o = '0;
    bank_lane_o = '0;
    conflict_o  = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int l = 0; l < LANES; l++) begin
        if (lane_en_i[l] && (lane_bank_i[l] == NBW'(b))) begin
          if (!bank_en_o[b]) begin
            bank_en_o[b]   = 1'b1;
            bank_addr_o[b] = lane_addr_i[l];
            bank_lane_o[b] = LW'(l);
          end else if (lane_addr_i[l] != bank_addr_o[b]) begin
            conflict_o = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/view_route_adapter.sv
module view_route_adapter
  import view_route_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int BANK_DEPTH = 3,
  parameter int SHRINK     = 2,
  parameter int LANES      = NUM_BANKS,
  parameter int IW         = $clog2(NUM_BANKS * BANK_DEPTH),
  parameter int AW         = $clog2(BANK_DEPTH),
  parameter int NBW        = $clog2(NUM_BANKS),
  parameter int LW         = $clog2(NUM_BANKS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cfg_we_i,
  input  logic [1:0]               cfg_mode_i,
  input  logic [IW-1:0]            cfg_base_i,
  input  logic [LANES-1:0]         lane_vld_i,
  input  logic [LANES*IW-1:0]      lane_idx_i,
  output logic [LANES*NBW-1:0]     lane_bank_o,
  output logic [LANES*AW-1:0]      lane_addr_o,
  output logic [LANES-1:0]         lane_en_o,
  output logic [LANES-1:0]         lane_oor_o,
  output logic [NUM_BANKS-1:0]     bank_en_o,
  output logic [NUM_BANKS*AW-1:0]  bank_addr_o,
  output logic [NUM_BANKS*LW-1:0]  bank_lane_o,
  output logic                     conflict_o
);
  localparam int G = NUM_BANKS / SHRINK;

  view_mode_e    mode_q;
  logic [IW-1:0] base_q;

  logic [LANES-1:0][NBW-1:0]    l_bank;
  logic [LANES-1:0][AW-1:0]     l_addr;
  logic [NUM_BANKS-1:0][AW-1:0] b_addr;
  logic [NUM_BANKS-1:0][LW-1:0] b_lane;

  view_cfg_reg #(.IW(IW)) u_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (cfg_we_i),
    .mode_i(cfg_mode_i),
    .base_i(cfg_base_i),
    .mode_o(mode_q),
    .base_o(base_q)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    view_lane_map #(
      .NUM_BANKS(NUM_BANKS), .BANK_DEPTH(BANK_DEPTH), .SHRINK(SHRINK),
      .LANE(l), .IW(IW), .AW(AW), .NBW(NBW)
    ) u_map (
      .mode_i(mode_q),
      .base_i(base_q),
      .vld_i (lane_vld_i[l]),
      .idx_i (lane_idx_i[l*IW +: IW]),
      .bank_o(l_bank[l]),
      .addr_o(l_addr[l]),
      .en_o  (lane_en_o[l]),
      .oor_o (lane_oor_o[l])
    );
    assign lane_bank_o[l*NBW +: NBW] = l_bank[l];
    assign lane_addr_o[l*AW +: AW]   = l_addr[l];

    AST_SUFFIX_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q == VM_SUFFIX && lane_en_o[l])
        |-> (l_bank[l] == lane_idx_i[l*IW +: NBW])); // R3

    if (l >= G) begin : g_idle
      AST_SHRINK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_q == VM_SHRINK) |-> !lane_en_o[l]); // R6
    end
  end

  view_bank_xbar #(
    .NUM_BANKS(NUM_BANKS), .LANES(LANES), .AW(AW), .NBW(NBW), .LW(LW)
  ) u_xbar (
    .lane_en_i  (lane_en_o),
    .lane_bank_i(l_bank),
    .lane_addr_i(l_addr),
    .bank_en_o  (bank_en_o),
    .bank_addr_o(b_addr),
    .bank_lane_o(b_lane),
    .conflict_o (conflict_o)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_addr_o[b*AW +: AW] = b_addr[b];
    assign bank_lane_o[b*LW +: LW] = b_lane[b];

    AST_BANK_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bank_en_o[b] |-> (int'(b_addr[b]) < BANK_DEPTH)); // R7
  end

  // lane l presents index l on every lane
  logic seq_idx;
  always_comb begin
    seq_idx = &lane_vld_i;
    for (int l = 0; l < LANES; l++)
      if (lane_idx_i[l*IW +: IW] != IW'(l)) seq_idx = 1'b0;
  end

  AST_SHIFT_DISJOINT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == VM_SHIFT && seq_idx) |-> !conflict_o); // R5
  AST_CONFLICT_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_o |-> ($countones(lane_en_o) >= 2)); // R9
endmodule

// File: tb/view_route_adapter_bench.sv
`timescale 1ns/1ps
module view_route_adapter_bench;
  localparam int N  = 4;
  localparam int D  = 3;
  localparam int S  = 2;
  localparam int L  = N;
  localparam int G  = N / S;
  localparam int IW = 4;
  localparam int AW = 2;
  localparam int NBW = 2;
  localparam int LW = 2;
  localparam int WORDS = N * D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_mode = '0;
  logic [IW-1:0] cfg_base = '0;
  logic [L-1:0] vld = '0;
  logic [L*IW-1:0] idx = '0;
  logic [L*NBW-1:0] lane_bank;
  logic [L*AW-1:0] lane_addr;
  logic [L-1:0] lane_en, lane_oor;
  logic [N-1:0] bank_en;
  logic [N*AW-1:0] bank_addr;
  logic [N*LW-1:0] bank_lane;
  logic conflict;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int m_mode = 0;
  int m_base = 0;

  always #10 clk = ~clk;

  view_route_adapter u_view_route_adapter (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_mode_i(cfg_mode),
    .cfg_base_i(cfg_base), .lane_vld_i(vld), .lane_idx_i(idx),
    .lane_bank_o(lane_bank), .lane_addr_o(lane_addr), .lane_en_o(lane_en),
    .lane_oor_o(lane_oor), .bank_en_o(bank_en), .bank_addr_o(bank_addr),
    .bank_lane_o(bank_lane), .conflict_o(conflict)
  );

  task automatic chk(input int act, input int exp, input string tag, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic write_cfg(input int mode, input int base);
    @(negedge clk);
    cfg_we = 1'b1; cfg_mode = 2'(mode); cfg_base = IW'(base);
    @(negedge clk);
    cfg_we = 1'b0;
    m_mode = mode; m_base = base;
  endtask

  task automatic set_lane(input int l, input int v, input int i);
    vld[l] = v[0];
    idx[l*IW +: IW] = IW'(i);
  endtask

  // full comparison of all outputs against the index model
  task automatic check_all(input string tag);
    int e_bank[L]; int e_addr[L]; int e_en[L]; int e_oor[L];
    int b_en[N]; int b_addr[N]; int b_lane[N];
    int e_conf;
    #2;
    e_conf = 0;
    for (int l = 0; l < L; l++) begin
      int i; int phys;
      i = int'(idx[l*IW +: IW]);
      if (m_mode == 0) phys = N * m_base + i;
      else if (m_mode == 2) phys = i;
      else phys = m_base + i;
      e_oor[l] = (phys >= WORDS);
      e_addr[l] = (phys / N) % (1 << AW);
      if (m_mode == 0) e_bank[l] = i % N;
      else if (m_mode == 2) e_bank[l] = ((i % N) / G) * G + (l % G);
      else e_bank[l] = phys % N;
      e_en[l] = vld[l] && !e_oor[l] && (m_mode != 2 || l < G);
    end
    for (int b = 0; b < N; b++) begin
      b_en[b] = 0; b_addr[b] = 0; b_lane[b] = 0;
      for (int l = 0; l < L; l++)
        if (e_en[l] && e_bank[l] == b) begin
          if (!b_en[b]) begin b_en[b] = 1; b_addr[b] = e_addr[l]; b_lane[b] = l; end
          else if (e_addr[l] != b_addr[b]) e_conf = 1;
        end
    end
    for (int l = 0; l < L; l++) begin
      chk(int'(lane_en[l]), e_en[l], tag, $sformatf("lane%0d en", l));
      chk(int'(lane_oor[l]), e_oor[l], tag, $sformatf("lane%0d oor", l));
      if (!e_oor[l]) begin
        chk(int'(lane_bank[l*NBW +: NBW]), e_bank[l], tag, $sformatf("lane%0d bank", l));
        chk(int'(lane_addr[l*AW +: AW]), e_addr[l], tag, $sformatf("lane%0d addr", l));
      end
    end
    for (int b = 0; b < N; b++) begin
      chk(int'(bank_en[b]), b_en[b], tag, $sformatf("bank%0d en", b));
      if (b_en[b]) begin
        chk(int'(bank_addr[b*AW +: AW]), b_addr[b], tag, $sformatf("bank%0d addr", b));
        chk(int'(bank_lane[b*LW +: LW]), b_lane[b], tag, $sformatf("bank%0d lane", b));
      end
    end
    chk(int'(conflict), e_conf, tag, "conflict");
  endtask

  task automatic t_reset();
    for (int l = 0; l < L; l++) set_lane(l, 1, l * 3);
    check_all("R1");
  endtask

  task automatic t_cfg_hold();
    write_cfg(1, 5);
    for (int l = 0; l < L; l++) set_lane(l, 1, l);
    check_all("R2");
    @(negedge clk);
    cfg_mode = 2'd2; cfg_base = 4'd9;
    @(negedge clk);
    check_all("R2");
  endtask

  task automatic t_suffix_sweep();
    for (int base = 0; base < 16; base++) begin
      write_cfg(0, base);
      for (int l = 0; l < L; l++) set_lane(l, 1, (l * 5 + base) % 16);
      check_all("R3");
    end
  endtask

  task automatic t_shift_sweep();
    for (int base = 0; base < 16; base++) begin
      write_cfg(1, base);
      for (int l = 0; l < L; l++) set_lane(l, 1, l);
      check_all("R4");
      chk(int'(conflict), 0, "R5", "shift consecutive conflict");
      for (int l = 0; l < L; l++) set_lane(l, 1, (l * 7 + base) % 12);
      check_all("R4");
    end
    write_cfg(3, 6);
    for (int l = 0; l < L; l++) set_lane(l, 1, l + 1);
    check_all("R4");
  endtask

  task automatic t_shrink_sweep();
    for (int base = 0; base < 16; base++) begin
      write_cfg(2, base);
      for (int l = 0; l < L; l++) set_lane(l, 1, (l % G) + G * ((base + l) % 6));
      check_all("R6");
      chk(int'(lane_en[L-1]), 0, "R6", "upper lane idle");
    end
  endtask

  task automatic t_oor();
    write_cfg(1, 10);
    set_lane(0, 1, 0); set_lane(1, 1, 1); set_lane(2, 1, 2); set_lane(3, 1, 5);
    check_all("R7");
    chk(int'(lane_oor[1]), 0, "R7", "last word in range");
    chk(int'(lane_oor[2]), 1, "R7", "first word past end");
    chk(int'(lane_en[3]), 0, "R7", "oor lane not routed");
    chk(int'(bank_en[0]), 0, "R7", "no wrap onto bank0");
  endtask

  task automatic t_bank_side();
    write_cfg(0, 0);
    set_lane(0, 1, 5); set_lane(1, 1, 5); set_lane(2, 1, 2); set_lane(3, 0, 3);
    check_all("R8");
    chk(int'(bank_lane[1*LW +: LW]), 0, "R8", "lowest lane owns bank1");
    chk(int'(bank_en[3]), 0, "R8", "invalid lane leaves bank3 idle");
    chk(int'(conflict), 0, "R9", "shared address no conflict");
    set_lane(0, 1, 1);
    check_all("R9");
    chk(int'(conflict), 1, "R9", "different addresses conflict");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg_hold();
    t_suffix_sweep();
    t_shift_sweep();
    t_shrink_sweep();
    t_oor();
    t_bank_side();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule